// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Core

This block is the combinational arithmetic and logic stage of a small accumulator datapath. One operand comes from the data bus (`opnd_a`) and the other comes from the accumulator (`opnd_b`). A three-bit function code picks one of eight results: a constant of all zeros, two subtraction orders, an addition, three bitwise operations, or a constant of all ones. The stage holds no state, so its outputs follow its inputs within the same evaluation.

The carry input always enters the add and both subtracts. Addition therefore behaves as add-with-carry. Each subtraction behaves as subtract-with-borrow, with the carry input taken as the borrow-in. For a plain add or subtract, the surrounding flag logic clears the carry first. The stage also reports an unsigned carry-out (a borrow on subtraction) and a signed overflow bit. The overflow bit is the XOR of the carry into and out of the sign position of the shared adder. Flag storage, flag selection, shifting and bus driving all sit outside this block.

Top module: `arith_core8`

## Requirements
- R1: Function code 3'b000 drives `result` to all zeros, for any operand and carry values.
- R2: Function code 3'b001 gives `result` = (B − A − carry_in) mod 2^W, and `carry_out` = 1 exactly when B < A + carry_in (a borrow occurred).
- R3: Function code 3'b010 gives `result` = (A − B − carry_in) mod 2^W, and `carry_out` = 1 exactly when A < B + carry_in.
- R4: Function code 3'b011 gives {`carry_out`, `result`} = A + B + carry_in, computed W+1 bits wide.
- R5: Function codes 3'b100, 3'b101 and 3'b110 drive `result` to A XOR B, A OR B and A AND B respectively.
- R6: Function code 3'b111 drives `result` to all ones.
- R7: For codes 001, 010 and 011, `ovf_out` is 1 exactly when the two's-complement result of the operation (including carry_in) lies outside the signed W-bit range. This equals the XOR of the carry into and the carry out of bit W−1 of the adder.
- R8: For codes 000, 100, 101, 110 and 111, `carry_out` and `ovf_out` are 0, and `carry_in` has no effect on any output.
- R9: The stage is purely combinational. Every output settles to the value for the present inputs before the next clock edge, with no dependence on earlier inputs. With carry_in = 1, the carry input changes the arithmetic result (for example, 0xFF + 0x00 + 1 gives 0x00 with carry_out = 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | W (8) | Operand taken from the data bus |
| opnd_b | input | W (8) | Operand taken from the accumulator |
| func_sel | input | 3 | Function code (see R1–R6 for each code) |
| carry_in | input | 1 | Carry-in for add, borrow-in for subtract |
| result | output | W (8) | Selected result |
| carry_out | output | 1 | Unsigned carry (add) or borrow (subtract), else 0 |
| ovf_out | output | 1 | Signed overflow for arithmetic codes, else 0 |

## Verification
The bench builds two copies of the block. One uses the default width of 8. The other uses a width of 4, which makes the full space of operands, carry values and function codes small enough to sweep completely: every carry-chain pattern and every signed boundary gets exercised. The 8-bit copy runs directed corner values: sign-boundary sums, a borrow through all bits, and carry-in rippling across an all-ones operand. It then runs a stretch of pseudo-random operands on all eight codes. At both widths, expected results come from signed and unsigned integer arithmetic, not from a carry chain.

// File: rtl/acore_pkg.sv
`timescale 1ns/1ps
// Shared types and bit-level arithmetic helpers for the arithmetic core.
package acore_pkg;

  // Function codes; the encoding is the external contract of func_sel.
  typedef enum logic [2:0] {
    OP_CLR   = 3'b000,
    OP_BSUBA = 3'b001,
    OP_ASUBB = 3'b010,
    OP_ADD   = 3'b011,
    OP_XOR   = 3'b100,
    OP_OR    = 3'b101,
    OP_AND   = 3'b110,
    OP_SET   = 3'b111
  } op_e;

  // Sum bit of a one-bit full adder.
  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  // Carry bit of a one-bit full adder (majority of the three inputs).
  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

  // Codes that route through the adder.
  function automatic logic op_is_arith(input op_e op);
    return (op == OP_BSUBA) || (op == OP_ASUBB) || (op == OP_ADD);
  endfunction

  // Codes that subtract (adder sees an inverted subtrahend).
  function automatic logic op_is_sub(input op_e op);
    return (op == OP_BSUBA) || (op == OP_ASUBB);
  endfunction

endpackage

// File: rtl/acore_operand_prep.sv
`timescale 1ns/1ps
// Steers operands into the single shared adder.
// Subtraction x - y - bin is done as x + ~y + ~bin.
module acore_operand_prep
  import acore_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic         c0_o
);

  always_comb begin
    x_o  = '0;
    y_o  = '0;
    c0_o = 1'b0;
    unique case (op_i)
      OP_ADD: begin
        x_o  = a_i;
        y_o  = b_i;
        c0_o = cin_i;
      end
      OP_BSUBA: begin
        // Minuend is the accumulator operand.
        x_o  = b_i;
        y_o  = ~a_i;
        c0_o = ~cin_i;
      end
      OP_ASUBB: begin
        // Minuend is the bus operand.
        x_o  = a_i;
        y_o  = ~b_i;
        c0_o = ~cin_i;
      end
      default: begin
        // Adder idles on zeros for logic and constant codes.
        x_o  = '0;
        y_o  = '0;
        c0_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/acore_ripple.sv
`timescale 1ns/1ps
// Ripple-carry adder built from one full-adder cell per bit.
// The carries at the sign position are exported for the overflow logic.
module acore_ripple
  import acore_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         c0_i,
  output logic [W-1:0] sum_o,
  output logic         msb_cin_o,
  output logic         msb_cout_o
);

  localparam int MSB = W - 1;

  // chain[k] is the carry entering bit k; chain[W] leaves the top bit.
  logic [W:0] chain;

  assign chain[0] = c0_i;

  generate
    for (genvar gi = 0; gi < W; gi++) begin : g_cell
      assign sum_o[gi]    = fa_sum(x_i[gi], y_i[gi], chain[gi]);
      assign chain[gi+1]  = fa_carry(x_i[gi], y_i[gi], chain[gi]);
    end
  endgenerate

  assign msb_cin_o  = chain[MSB];
  assign msb_cout_o = chain[W];

endmodule

// File: rtl/acore_logic.sv
`timescale 1ns/1ps
// Bitwise unit: one result vector for the three logic codes.
module acore_logic
  import acore_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] lres_o
);

  always_comb begin
    unique case (op_i)
      OP_XOR:  lres_o = a_i ^ b_i;
      OP_OR:   lres_o = a_i | b_i;
      OP_AND:  lres_o = a_i & b_i;
      default: lres_o = '0;
    endcase
  end

endmodule

// File: rtl/acore_out_sel.sv
`timescale 1ns/1ps
// Final result and flag selection.
module acore_out_sel
  import acore_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op_i,
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] lres_i,
  input  logic         msb_cin_i,
  input  logic         msb_cout_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         ovf_o
);

  logic arith;
  logic sub;

  assign arith = op_is_arith(op_i);
  assign sub   = op_is_sub(op_i);

  always_comb begin
    unique case (op_i)
      OP_CLR:                   result_o = '0;
      OP_SET:                   result_o = '1;
      OP_BSUBA, OP_ASUBB, OP_ADD: result_o = sum_i;
      default:                  result_o = lres_i;
    endcase
  end

  // A raw carry of 1 on x + ~y + ~bin means no borrow, so invert on subtract.
  assign carry_o = arith & (sub ? ~msb_cout_i : msb_cout_i);
  // Signed overflow: carries into and out of the sign bit disagree.
  assign ovf_o   = arith & (msb_cin_i ^ msb_cout_i);

endmodule

// File: rtl/arith_core8.sv
`timescale 1ns/1ps
// Combinational arithmetic and logic core.
module arith_core8
  import acore_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [2:0]   func_sel,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         ovf_out
);

  op_e          op;
  logic [W-1:0] add_x;
  logic [W-1:0] add_y;
  logic         add_c0;
  logic [W-1:0] add_sum;
  logic [W-1:0] logic_res;
  // Internal events brought out by name for the checker.
  logic         msb_cin;
  logic         msb_cout;
  logic         arith_active;

  assign op           = op_e'(func_sel);
  assign arith_active = op_is_arith(op);

  acore_operand_prep #(.W(W)) u_prep (
    .op_i  (op),
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .cin_i (carry_in),
    .x_o   (add_x),
    .y_o   (add_y),
    .c0_o  (add_c0)
  );

  acore_ripple #(.W(W)) u_adder (
    .x_i        (add_x),
    .y_i        (add_y),
    .c0_i       (add_c0),
    .sum_o      (add_sum),
    .msb_cin_o  (msb_cin),
    .msb_cout_o (msb_cout)
  );

  acore_logic #(.W(W)) u_logic (
    .op_i   (op),
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .lres_o (logic_res)
  );

  acore_out_sel #(.W(W)) u_sel (
    .op_i       (op),
    .sum_i      (add_sum),
    .lres_i     (logic_res),
    .msb_cin_i  (msb_cin),
    .msb_cout_i (msb_cout),
    .result_o   (result),
    .carry_o    (carry_out),
    .ovf_o      (ovf_out)
  );

endmodule

// File: rtl/arith_core8_checker.sv
`timescale 1ns/1ps
// Immediate-assertion checker for the combinational core.
module arith_core8_checker #(
  parameter int W = 8
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [2:0]   func_sel,
  input logic         carry_in,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         ovf_out,
  input logic         msb_cin,
  input logic         msb_cout,
  input logic         arith_active
);

  logic [W:0] wide_sum;
  logic [W:0] wide_a_minus_b;
  logic [W:0] wide_b_minus_a;

  always_comb begin
    wide_sum       = {1'b0, opnd_a} + {1'b0, opnd_b} + {{W{1'b0}}, carry_in};
    wide_a_minus_b = {1'b0, opnd_a} - {1'b0, opnd_b} - {{W{1'b0}}, carry_in};
    wide_b_minus_a = {1'b0, opnd_b} - {1'b0, opnd_a} - {{W{1'b0}}, carry_in};
  end

  always_comb begin
    if (func_sel == 3'b000)
      a_r1_zero_code: assert (result == '0) else $error("R1 zero code");
    if (func_sel == 3'b001)
      a_r2_b_minus_a: assert ({carry_out, result} == wide_b_minus_a) else $error("R2 B-A");
    if (func_sel == 3'b010)
      a_r3_a_minus_b: assert ({carry_out, result} == wide_a_minus_b) else $error("R3 A-B");
    if (func_sel == 3'b011)
      a_r4_add_total: assert ({carry_out, result} == wide_sum) else $error("R4 add");
    if (func_sel == 3'b100)
      a_r5_xor: assert (result == (opnd_a ^ opnd_b)) else $error("R5 xor");
    if (func_sel == 3'b101)
      a_r5_or: assert (result == (opnd_a | opnd_b)) else $error("R5 or");
    if (func_sel == 3'b110)
      a_r5_and: assert (result == (opnd_a & opnd_b)) else $error("R5 and");
    if (func_sel == 3'b111)
      a_r6_ones_code: assert (result == '1) else $error("R6 ones code");
    if (arith_active)
      a_r7_ovf_from_carries: assert (ovf_out == (msb_cin ^ msb_cout)) else $error("R7 overflow");
    if (!arith_active)
      a_r8_flags_quiet: assert (!carry_out && !ovf_out) else $error("R8 flags");
  end

endmodule

bind arith_core8 arith_core8_checker #(.W(W)) u_chk (
  .opnd_a       (opnd_a),
  .opnd_b       (opnd_b),
  .func_sel     (func_sel),
  .carry_in     (carry_in),
  .result       (result),
  .carry_out    (carry_out),
  .ovf_out      (ovf_out),
  .msb_cin      (msb_cin),
  .msb_cout     (msb_cout),
  .arith_active (arith_active)
);

// File: tb/test_arith_core8.sv
`timescale 1ns/1ps
module test_arith_core8;

  typedef struct {
    int    w;
    int    op;
    int    a;
    int    b;
    int    cin;
    int    res;
    int    co;
    int    ov;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  // 8-bit copy
  logic [7:0] a8 = '0, b8 = '0, r8;
  logic [2:0] s8 = '0;
  logic       c8 = 1'b0, co8, ov8;
  // 4-bit copy, swept exhaustively
  logic [3:0] a4 = '0, b4 = '0, r4;
  logic [2:0] s4 = '0;
  logic       c4 = 1'b0, co4, ov4;

  arith_core8 #(.W(8)) i_arith_core8 (
    .opnd_a(a8), .opnd_b(b8), .func_sel(s8), .carry_in(c8),
    .result(r8), .carry_out(co8), .ovf_out(ov8)
  );

  arith_core8 #(.W(4)) i_arith_core8_w4 (
    .opnd_a(a4), .opnd_b(b4), .func_sel(s4), .carry_in(c4),
    .result(r4), .carry_out(co4), .ovf_out(ov4)
  );

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model from integer arithmetic (R1..R8).
  function automatic void model(input int w, input int op, input int a, input int b,
                                input int cin, output int res, output int co, output int ov);
    int m, full, h, sa, sb, t, st;
    m = (1 << w) - 1; full = 1 << w; h = 1 << (w - 1);
    sa = (a >= h) ? a - full : a;
    sb = (b >= h) ? b - full : b;
    res = 0; co = 0; ov = 0;
    case (op)
      1: begin t = b - a - cin; st = sb - sa - cin;
               res = t & m; co = (t < 0) ? 1 : 0; ov = (st < -h || st > h - 1) ? 1 : 0; end
      2: begin t = a - b - cin; st = sa - sb - cin;
               res = t & m; co = (t < 0) ? 1 : 0; ov = (st < -h || st > h - 1) ? 1 : 0; end
      3: begin t = a + b + cin; st = sa + sb + cin;
               res = t & m; co = (t > m) ? 1 : 0; ov = (st < -h || st > h - 1) ? 1 : 0; end
      4: res = a ^ b;
      5: res = a | b;
      6: res = a & b;
      7: res = m;
      default: res = 0;
    endcase
  endfunction

  function automatic string req_of(input int op);
    case (op)
      0: return "R1 R8";
      1: return "R2 R7";
      2: return "R3 R7";
      3: return "R4 R7";
      7: return "R6 R8";
      default: return "R5 R8";
    endcase
  endfunction

  // Driver: applies one vector after a rising edge and queues the expectation.
  task automatic apply(input int w, input int op, input int a, input int b,
                       input int cin, input string extra);
    item_t it;
    @(posedge clk);
    #1;
    if (w == 8) begin
      a8 = a[7:0]; b8 = b[7:0]; s8 = op[2:0]; c8 = cin[0];
    end else begin
      a4 = a[3:0]; b4 = b[3:0]; s4 = op[2:0]; c4 = cin[0];
    end
    it.w = w; it.op = op; it.a = a; it.b = b; it.cin = cin;
    model(w, op, a, b, cin, it.res, it.co, it.ov);
    it.req = {req_of(op), extra};
    q.push_back(it);
  endtask

  // Monitor: compares at the falling edge, away from the driving edge (R9).
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      int ar, ac, av;
      it = q.pop_front();
      if (it.w == 8) begin ar = int'(r8); ac = int'(co8); av = int'(ov8); end
      else           begin ar = int'(r4); ac = int'(co4); av = int'(ov4); end
      checks++;
      if (ar != it.res || ac != it.co || av != it.ov) begin
        errors++;
        $display("FAIL %s w=%0d op=%0d a=%0h b=%0h cin=%0d: actual res=%0h co=%0d ov=%0d expected res=%0h co=%0d ov=%0d",
                 it.req, it.w, it.op, it.a, it.b, it.cin, ar, ac, av, it.res, it.co, it.ov);
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    // Idle state after reset: all-zero inputs give zero outputs (R1).
    apply(8, 0, 0, 0, 0, " reset");
    // R7: sign-boundary cases on the 4-bit copy.
    apply(4, 3, 4, 5, 0, " 4+5 overflows");
    apply(4, 3, 12, 14, 0, " -4+-2 in range");
    // R9: carry-in ripples across all ones.
    apply(8, 3, 8'hFF, 8'h00, 1, " R9 ripple");
    apply(8, 2, 8'h00, 8'h00, 1, " R9 borrow chain");
    apply(8, 1, 8'h00, 8'h00, 1, " R9 borrow chain");
    apply(8, 3, 8'h7F, 8'h00, 1, " R9 into sign");
    apply(8, 2, 8'h80, 8'h01, 0, " min minus one");
    apply(8, 1, 8'h01, 8'h80, 0, " min minus one");
    apply(8, 3, 8'h80, 8'h80, 0, " two mins");
    // R8: carry_in toggled on logic and constant codes must change nothing.
    for (int op = 0; op < 8; op++) begin
      if (op == 0 || op >= 4) begin
        apply(8, op, 8'hA5, 8'h3C, 0, " cin0");
        apply(8, op, 8'hA5, 8'h3C, 1, " cin1");
      end
    end
    // Exhaustive sweep of the 4-bit copy (R1..R9).
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int c = 0; c < 2; c++)
            apply(4, op, a, b, c, " sweep");
    // Pseudo-random vectors on the 8-bit copy.
    for (int i = 0; i < 3000; i++)
      apply(8, i % 8, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 1)), " random");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  // Watchdog and summary.
  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual run still busy, expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule